// File: doc/BRIEF.md
# Decoded-Access Register Slave

This block is the user-side end of a peripheral attachment. Upstream logic has already turned the host bus into a block select, a read flag, and one read enable and one write enable per register. It has also supplied byte-lane enables and write data. The slave holds a bank of four 32-bit locations and answers each access with one response pulse.

The possible responses are:
- an acknowledge, which may carry an error flag;
- a retry, sent instead of an acknowledge.

Location 0 is a control word. Its bit 0 is a busy flag. Location 1 is a plain scratch word. Location 2 stands for a slow resource: it answers after a fixed long delay and raises a timeout-suppress flag while the answer is pending. Location 3 is a read-only status word.

The requester presents an access and holds it stable until it sees a response. It drops the access in the cycle after that response.

Top module: `regslv_top`

## Requirements
- R1: After reset, ack, err, retry and toutSup are low, rdData is zero and locations 0, 1 and 2 read as zero.
- R2: A write to location 0, 1 or 2 updates only the byte lanes whose enable bit is 1, where enable bit i covers data bits 8i+7 down to 8i. Enable value 0 leaves the location unchanged but still acknowledges.
- R3: Count the cycle in which a request first appears as cycle 0. Locations 0, 1 and 3 acknowledge in cycle 1. rdData carries the read value only in the acknowledge cycle and is zero in every other cycle.
- R4: An access is recognised only when busCs is 1 and the enable vector chosen by rnw has a bit set. rnw=1 selects rdCe (a read) and rnw=0 selects wrCe (a write); enable bit i selects location i. Anything else produces no response and changes no location.
- R5: An access to location 2 with busy clear acknowledges in cycle 12. A write takes effect with that acknowledge, and a read returns the location's value in that cycle.
- R6: During an acknowledged access to location 2, toutSup is 1 in cycles 1 through 12. It is 0 during every other access, including retried ones.
- R7: While bit 0 of location 0 is 1, an access to location 2 gets a retry pulse in cycle 1. That access gets no acknowledge and leaves the location unchanged.
- R8: A read of location 3 returns {16'h5EA1, 15 zero bits, busy bit}. A write to location 3 gets ack with err in cycle 1 and changes nothing.
- R9: An access whose selected enable vector has more than one bit set gets ack with err in cycle 1 and writes no location.
- R10: err is 1 only together with ack. ack and retry are never 1 together, and each of them lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCs | input | 1 | Block select from the decoding interface |
| rnw | input | 1 | 1 for a read, 0 for a write |
| rdCe | input | 4 | Per-location read enables |
| wrCe | input | 4 | Per-location write enables |
| be | input | 4 | Byte-lane enables for writes |
| wrData | input | 32 | Write data |
| ack | output | 1 | Acknowledge pulse |
| rdData | output | 32 | Read data, valid with ack |
| err | output | 1 | Error flag, meaningful with ack |
| retry | output | 1 | Retry pulse, given instead of ack |
| toutSup | output | 1 | Response will take longer than the bus timeout |

## Verification
The hardest case to reach is a retry on the slow location. It needs the busy bit to be set first through an ordinary write to location 0. The retried read and the retried write must then be shown to leave location 2 untouched. The bench therefore sets busy, issues both kinds of access to location 2, clears busy, and reads location 2 back through the full 12-cycle path. A scoreboard checks the latency of every response against the cycle in which its request started. It also checks toutSup cycle by cycle while each response is awaited.

// File: rtl/regslv_pkg.sv
package regslv_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NREG     = 4;
  localparam int IDXW     = $clog2(NREG);
  localparam int CTRL_IDX = 0;
  localparam int SLOW_IDX = 2;
  localparam int STAT_IDX = 3;

  typedef struct packed {
    logic            wrStrobe;
    logic            rdCapture;
    logic [IDXW-1:0] regIdx;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOW = 2'd1,
    ST_RESP = 2'd2
  } state_t;
endpackage

// File: rtl/regslv_ctrl.sv
module regslv_ctrl
  import regslv_pkg::*;
#(
  parameter int SLOW_LAT = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busCs,
  input  logic            rnw,
  input  logic [NREG-1:0] rdCe,
  input  logic [NREG-1:0] wrCe,
  input  logic            busy,
  output strobe_t         stb,
  output logic            ack,
  output logic            err,
  output logic            retry,
  output logic            toutSup
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CNTW = $clog2(SLOW_LAT + 1);

  state_t          state;
  logic [CNTW-1:0] cnt;
  logic [IDXW-1:0] slowIdx;
  logic            slowRnw;

  logic [NREG-1:0] ceSel;
  logic            reqValid;
  logic            multiHit;
  logic [IDXW-1:0] liveIdx;
  logic            roWrite;
  logic            fastOk;
  logic            slowDone;

  always_comb begin
    ceSel    = rnw ? rdCe : wrCe;
    reqValid = busCs && (|ceSel);
    multiHit = !$onehot(ceSel);
    liveIdx  = '0;
    for (int i = 0; i < NREG; i++) begin
      if (ceSel[i]) liveIdx = IDXW'(i);
    end
  end

  assign roWrite  = (liveIdx == IDXW'(STAT_IDX)) && !rnw;
  assign fastOk   = (state == ST_IDLE) && reqValid && !multiHit && !roWrite
                    && (liveIdx != IDXW'(SLOW_IDX));
  assign slowDone = (state == ST_SLOW) && (cnt == CNTW'(SLOW_LAT - 1));

  always_comb begin
    stb.wrStrobe  = (fastOk && !rnw) || (slowDone && !slowRnw);
    stb.rdCapture = (fastOk && rnw) || (slowDone && slowRnw);
    stb.regIdx    = (state == ST_SLOW) ? slowIdx : liveIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      slowIdx <= '0;
      slowRnw <= 1'b0;
      ack     <= 1'b0;
      err     <= 1'b0;
      retry   <= 1'b0;
      toutSup <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (multiHit || roWrite) begin
              ack   <= 1'b1;
              err   <= 1'b1;
              state <= ST_RESP;
            end else if (liveIdx == IDXW'(SLOW_IDX)) begin
              if (busy) begin
                retry <= 1'b1;
                state <= ST_RESP;
              end else begin
                cnt     <= CNTW'(1);
                toutSup <= 1'b1;
                slowIdx <= liveIdx;
                slowRnw <= rnw;
                state   <= ST_SLOW;
              end
            end else begin
              ack   <= 1'b1;
              state <= ST_RESP;
            end
          end
        end
        ST_SLOW: begin
          cnt <= cnt + CNTW'(1);
          if (slowDone) begin
            ack   <= 1'b1;
            state <= ST_RESP;
          end
        end
        ST_RESP: begin
          ack     <= 1'b0;
          err     <= 1'b0;
          retry   <= 1'b0;
          toutSup <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: response signalling rules
  a_r10_ack_retry_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(ack && retry));
  a_r10_err_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    err |-> ack);
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);
  a_r10_retry_pulse: assert property (@(posedge clk) disable iff (!rstN)
    retry |=> !retry);
  // R6: timeout suppression stays up until the acknowledge, then drops
  a_r6_tsup_hold: assert property (@(posedge clk) disable iff (!rstN)
    (toutSup && !ack) |=> toutSup);
  a_r6_tsup_drop: assert property (@(posedge clk) disable iff (!rstN)
    (toutSup && ack) |=> !toutSup);
  // R7: a retry never carries timeout suppression
  a_r7_retry_no_tsup: assert property (@(posedge clk) disable iff (!rstN)
    retry |-> !toutSup);
endmodule

// File: rtl/regslv_datapath.sv
module regslv_datapath
  import regslv_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [15:0] STATUS_TAG = 16'h5EA1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                busy
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int LANES = DATA_W / 8;
  localparam int NSTORE = STAT_IDX;

  logic [DATA_W-1:0] regQ [NSTORE];
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] rdMux;

  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ[g] <= '0;
      end else if (stb.wrStrobe && (stb.regIdx == IDXW'(g))) begin
        for (int l = 0; l < LANES; l++) begin
          if (be[l]) regQ[g][8*l +: 8] <= wrData[8*l +: 8];
        end
      end
    end

    // R4: storage changes only under a write strobe aimed at it
    a_r4_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
      !(stb.wrStrobe && (stb.regIdx == IDXW'(g))) |=> $stable(regQ[g]));
  end

  assign busy       = regQ[CTRL_IDX][0];
  assign statusWord = {STATUS_TAG, {(DATA_W-17){1'b0}}, busy};

  always_comb begin
    rdMux = statusWord;
    for (int i = 0; i < NSTORE; i++) begin
      if (stb.regIdx == IDXW'(i)) rdMux = regQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= stb.rdCapture ? rdMux : '0;
  end
endmodule

// File: rtl/regslv_top.sv
module regslv_top
  import regslv_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          SLOW_LAT   = 12,
  parameter logic [15:0] STATUS_TAG = 16'h5EA1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busCs,
  input  logic                rnw,
  input  logic [NREG-1:0]     rdCe,
  input  logic [NREG-1:0]     wrCe,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wrData,
  output logic                ack,
  output logic [DATA_W-1:0]   rdData,
  output logic                err,
  output logic                retry,
  output logic                toutSup
);
  timeunit 1ns;
  timeprecision 100ps;

  strobe_t stb;
  logic    busy;

  regslv_ctrl #(.SLOW_LAT(SLOW_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .busCs(busCs), .rnw(rnw), .rdCe(rdCe),
    .wrCe(wrCe), .busy(busy), .stb(stb), .ack(ack), .err(err),
    .retry(retry), .toutSup(toutSup)
  );

  regslv_datapath #(.DATA_W(DATA_W), .STATUS_TAG(STATUS_TAG)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .be(be), .wrData(wrData),
    .rdData(rdData), .busy(busy)
  );

  // R3: read data is zero outside the acknowledge cycle
  a_r3_rd_only_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    !ack |-> (rdData == '0));
endmodule

// File: tb/tb_regslv_top.sv
module tb_regslv_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busCs = 1'b0;
  logic        rnw = 1'b0;
  logic [3:0]  rdCe = '0;
  logic [3:0]  wrCe = '0;
  logic [3:0]  be = '0;
  logic [31:0] wrData = '0;
  logic        ack, err, retry, toutSup;
  logic [31:0] rdData;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    bit          isRetry;
    bit          expErr;
    logic [31:0] data;
    int          lat;
    int          start;
    string       tag;
  } exp_t;

  exp_t        q[$];
  exp_t        cur;
  logic [31:0] model[3];

  regslv_top dut (
    .clk(clk), .rstN(rstN), .busCs(busCs), .rnw(rnw), .rdCe(rdCe),
    .wrCe(wrCe), .be(be), .wrData(wrData), .ack(ack), .rdData(rdData),
    .err(err), .retry(retry), .toutSup(toutSup)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: pops expected responses as the design produces them
  always @(negedge clk) begin
    if (rstN && !done && (ack || retry)) begin
      if (q.size() == 0) begin
        check(1'b0, "R4/R10 unexpected response", {62'd0, ack, retry}, 64'd0);
      end else begin
        cur = q.pop_front();
        check((retry == cur.isRetry) && (ack == !cur.isRetry) && (err == cur.expErr)
              && (rdData == cur.data) && ((cyc - cur.start) == cur.lat),
              cur.tag,
              {16'(cyc - cur.start), 13'd0, ack, retry, err, rdData},
              {16'(cur.lat), 13'd0, !cur.isRetry, cur.isRetry, cur.expErr, cur.data});
      end
    end
  end

  function automatic logic [31:0] statusExp();
    return {16'h5EA1, 15'd0, model[0][0]};
  endfunction

  task automatic access(input bit rd, input logic [3:0] ce, input logic [3:0] bMask,
                        input logic [31:0] d, input string tag);
    exp_t e;
    int   idx = 0;
    bit   slow = 0;
    int   k = 0;
    int   tsBad = 0;
    for (int i = 0; i < 4; i++) if (ce[i]) idx = i;
    e.isRetry = 0; e.expErr = 0; e.data = '0; e.lat = 1; e.tag = tag;
    if (!$onehot(ce)) e.expErr = 1;
    else if (idx == 3) begin
      if (rd) e.data = statusExp(); else e.expErr = 1;
    end else if (idx == 2 && model[0][0]) e.isRetry = 1;
    else begin
      if (idx == 2) begin e.lat = 12; slow = 1; end
      if (rd) e.data = model[idx];
      else for (int l = 0; l < 4; l++) if (bMask[l]) model[idx][8*l +: 8] = d[8*l +: 8];
    end
    @(negedge clk);
    busCs = 1'b1; rnw = rd; rdCe = rd ? ce : 4'd0; wrCe = rd ? 4'd0 : ce;
    be = bMask; wrData = d;
    e.start = cyc;
    q.push_back(e);
    do begin
      @(negedge clk);
      k++;
      if (toutSup != (slow && k <= 12)) tsBad++;
    end while (!(ack || retry) && k < 40);
    busCs = 1'b0; rdCe = '0; wrCe = '0; be = '0; wrData = '0;
    check(tsBad == 0, {"R6 toutSup profile ", tag}, 64'(tsBad), 64'd0);
  endtask

  task automatic ignored(input bit cs, input bit rd, input logic [3:0] rc,
                         input logic [3:0] wc, input string tag);
    int seen = 0;
    @(negedge clk);
    busCs = cs; rnw = rd; rdCe = rc; wrCe = wc; be = 4'hF; wrData = 32'hFFFF_FFFF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (ack || retry || toutSup) seen++;
    end
    busCs = 1'b0; rdCe = '0; wrCe = '0; be = '0; wrData = '0;
    check(seen == 0, tag, 64'(seen), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!ack && !err && !retry && !toutSup && rdData == '0, "R1 reset outputs",
          {28'd0, ack, err, retry, toutSup, rdData}, 64'd0);
    access(1, 4'b0001, 4'h0, '0, "R1 reg0 after reset");
    access(1, 4'b0010, 4'h0, '0, "R1 reg1 after reset");
    access(1, 4'b0100, 4'h0, '0, "R1/R5 reg2 after reset");

    access(0, 4'b0010, 4'hF, 32'hDEAD_BEEF, "R2 full write reg1");
    access(1, 4'b0010, 4'h0, '0, "R3 read reg1");
    access(0, 4'b0010, 4'b0101, 32'h1122_3344, "R2 lane write reg1");
    access(1, 4'b0010, 4'h0, '0, "R2 lanes 0,2 only");
    access(0, 4'b0001, 4'h0, 32'hFFFF_FFFF, "R2 empty byte mask reg0");
    access(1, 4'b0001, 4'h0, '0, "R2 reg0 unchanged by empty mask");

    access(0, 4'b0100, 4'hF, 32'hCAFE_F00D, "R5 slow write reg2");
    access(1, 4'b0100, 4'h0, '0, "R5 slow read reg2");
    access(0, 4'b0100, 4'b1000, 32'h7700_0000, "R5 slow lane write");
    access(1, 4'b0100, 4'h0, '0, "R5 slow read after lane write");

    access(1, 4'b1000, 4'h0, '0, "R8 status busy clear");
    access(0, 4'b1000, 4'hF, 32'h1234_5678, "R8 write to status errors");
    access(1, 4'b1000, 4'h0, '0, "R8 status unchanged");

    access(0, 4'b0001, 4'b0001, 32'h0000_0001, "R7 set busy");
    access(1, 4'b1000, 4'h0, '0, "R8 status busy set");
    access(1, 4'b0100, 4'h0, '0, "R7 read reg2 retried");
    access(0, 4'b0100, 4'hF, 32'h0BAD_0BAD, "R7 write reg2 retried");
    access(1, 4'b0010, 4'h0, '0, "R7 busy leaves reg1 fast");
    access(0, 4'b0001, 4'b0001, 32'h0, "R7 clear busy");
    access(1, 4'b0100, 4'h0, '0, "R7 reg2 untouched by retried write");

    access(0, 4'b0011, 4'hF, 32'h5555_AAAA, "R9 two write enables");
    access(1, 4'b0110, 4'h0, '0, "R9 two read enables");
    access(1, 4'b0001, 4'h0, '0, "R9 reg0 unchanged");
    access(1, 4'b0010, 4'h0, '0, "R9 reg1 unchanged");

    ignored(1'b0, 1'b0, 4'b0000, 4'b0010, "R4 no response without busCs");
    ignored(1'b1, 1'b1, 4'b0000, 4'b0010, "R4 no response rnw/enable mismatch");
    ignored(1'b1, 1'b0, 4'b0100, 4'b0000, "R4 no response write with read enable");
    access(1, 4'b0010, 4'h0, '0, "R4 reg1 unchanged after ignored");
    access(1, 4'b0100, 4'h0, '0, "R4 reg2 unchanged after ignored");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R10 all responses seen", 64'(q.size()), 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule